// File: doc/BRIEF.md
# Memory Request Slot Tracker

This block keeps the book of outstanding memory accesses for one cache port of a multithreaded in-order pipeline. A small pool of request slots holds, for each live access, its thread id, its sequence number and its address. A pipeline stage asks for a slot with a thread id, sequence number and address. The grant, a one-hot slot vector with a valid bit, comes back combinationally in the same cycle. The owner later returns the slot through the free port.

Requests are refused in three cases. The first is a thread that is locked out after a translation fault. The second is a data port whose address matches an outstanding access; an instruction-port build skips this address check. The third is a pool with no free slot. A pipeline flush squashes the younger slots of one thread. A squashed slot is released at once only when it is idle. A squashed slot with a memory access in flight stays allocated until its response arrives, and that response is then flagged for discard. A squashed slot stalled on translation lifts its thread's lockout at once and is released when its translation wake-up arrives.

Top module: `mem_slot_tracker`

## Requirements
- R1: After reset no slot is busy (`slot_busy` = 0), no thread is blocked (`thread_blocked` = 0) and `grant_valid` is 0.
- R2: A request from a thread whose bit in `thread_blocked` is 1 is refused (`grant_valid` = 0, `grant_slot` = 0).
- R3: With `DATA_PORT` = 1, a request whose address equals the address of any busy slot not being freed in the same cycle is refused.
- R4: With `DATA_PORT` = 0, the address comparison is skipped, so a duplicate address is granted when a slot is free.
- R5: A grant is decided in the request cycle. `grant_slot` is one-hot, bit i selecting slot i, and picks the lowest-numbered free slot. That slot reads busy from the next cycle on. `grant_slot` is 0 whenever `grant_valid` is 0.
- R6: When every slot is busy and none is being freed, a request is refused even with no address conflict.
- R7: A free and a request in the same cycle resolve free-first. The freed slot is available to the request, and its address no longer conflicts.
- R8: A squash selects the busy slots whose thread equals `squash_tid` and whose sequence number is strictly younger than `squash_seq`. Younger means that (slot_seq − squash_seq) mod 2^16 is nonzero and below 2^15.
- R9: A selected slot that is neither translation-stalled nor waiting on memory reads not busy in the next cycle.
- R10: A selected slot with a memory access pending stays busy until its response. That response raises `resp_discard` in its cycle and frees the slot. A response to a slot that is not squashed leaves `resp_discard` at 0 and leaves the slot busy.
- R11: A translation fault on a busy slot sets its thread's `thread_blocked` bit from the next cycle. The translation wake-up for that slot clears the bit again.
- R12: Squashing a translation-stalled slot clears its thread's blocked bit from the next cycle but keeps the slot busy. The later wake-up for that slot frees it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Slot request strobe |
| req_tid | input | 1 | Requesting thread |
| req_seq | input | 16 | Sequence number of the requesting access |
| req_addr | input | 32 | Address of the requesting access |
| grant_valid | output | 1 | Request accepted this cycle |
| grant_slot | output | 4 | One-hot granted slot |
| free_valid | input | 1 | Slot release strobe |
| free_slot | input | 2 | Index of the slot to release |
| squash_valid | input | 1 | Flush strobe |
| squash_tid | input | 1 | Thread being flushed |
| squash_seq | input | 16 | Oldest surviving sequence number |
| issue_valid | input | 1 | Memory access sent for a slot |
| issue_slot | input | 2 | Slot whose access was sent |
| resp_valid | input | 1 | Memory response arrives |
| resp_slot | input | 2 | Slot the response belongs to |
| resp_discard | output | 1 | Current response belongs to a squashed slot |
| xlat_fault_valid | input | 1 | Translation fault strobe |
| xlat_fault_slot | input | 2 | Slot that faulted |
| xlat_wake_valid | input | 1 | Translation wake-up strobe |
| xlat_wake_slot | input | 2 | Slot being woken |
| slot_busy | output | 4 | Occupancy of each slot |
| thread_blocked | output | 2 | Translation lockout per thread |

## Verification
The assertions take for granted that issue, response, fault and wake-up strobes name busy slots. They also assume a response only follows an issue, and that sequence numbers of live slots of one thread lie within half the sequence space of each other. The directed part of the stimulus follows that order of events by hand. The random part drives only requests and frees of slots that the bench's own occupancy model shows busy. Its sequence numbers rise monotonically, and its addresses come from a small set, so duplicate-address refusals happen often.

// File: rtl/mst_pkg.sv
package mst_pkg;

    typedef struct packed {
        logic busy;
        logic pending;
        logic stall;
        logic squashed;
    } slot_flags_t;

    localparam slot_flags_t SLOT_IDLE = '0;

    // A squashed slot can be released on the spot only when nothing is in flight for it.
    function automatic logic squash_frees_now(slot_flags_t f);
        return !f.stall && !f.pending;
    endfunction

    // Modular age test taken from the sign bit and zero flag of (slot - reference).
    function automatic logic is_younger(logic diff_msb, logic diff_nonzero);
        return !diff_msb && diff_nonzero;
    endfunction

endpackage

// File: rtl/mst_pick.sv
module mst_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] cand,
    output logic [N-1:0] first,
    output logic         any
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar gi = 0; gi < N; gi++) begin : g_pick
        assign first[gi]  = cand[gi] && !seen[gi];
        assign seen[gi+1] = seen[gi] || cand[gi];
    end

    assign any = seen[N];
endmodule

// File: rtl/mst_addr_cam.sv
module mst_addr_cam #(
    parameter int N  = 4,
    parameter int AW = 32
) (
    input  logic [AW-1:0] entry [N],
    input  logic [AW-1:0] key,
    output logic [N-1:0]  hit
);
    for (genvar gi = 0; gi < N; gi++) begin : g_cmp
        assign hit[gi] = (entry[gi] == key);
    end
endmodule

// File: rtl/mem_slot_tracker.sv
module mem_slot_tracker
    import mst_pkg::*;
#(
    parameter int NUM_SLOTS   = 4,
    parameter int NUM_THREADS = 2,
    parameter int ADDR_W      = 32,
    parameter int SEQ_W       = 16,
    parameter bit DATA_PORT   = 1'b1,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int TID_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [TID_W-1:0]       req_tid,
    input  logic [SEQ_W-1:0]       req_seq,
    input  logic [ADDR_W-1:0]      req_addr,
    output logic                   grant_valid,
    output logic [NUM_SLOTS-1:0]   grant_slot,
    input  logic                   free_valid,
    input  logic [SLOT_W-1:0]      free_slot,
    input  logic                   squash_valid,
    input  logic [TID_W-1:0]       squash_tid,
    input  logic [SEQ_W-1:0]       squash_seq,
    input  logic                   issue_valid,
    input  logic [SLOT_W-1:0]      issue_slot,
    input  logic                   resp_valid,
    input  logic [SLOT_W-1:0]      resp_slot,
    output logic                   resp_discard,
    input  logic                   xlat_fault_valid,
    input  logic [SLOT_W-1:0]      xlat_fault_slot,
    input  logic                   xlat_wake_valid,
    input  logic [SLOT_W-1:0]      xlat_wake_slot,
    output logic [NUM_SLOTS-1:0]   slot_busy,
    output logic [NUM_THREADS-1:0] thread_blocked
);

    slot_flags_t             flags_q [NUM_SLOTS];
    slot_flags_t             flags_d [NUM_SLOTS];
    logic [ADDR_W-1:0]       addr_q  [NUM_SLOTS];
    logic [SEQ_W-1:0]        seq_q   [NUM_SLOTS];
    logic [TID_W-1:0]        tid_q   [NUM_SLOTS];
    logic [NUM_THREADS-1:0]  blocked_q, blocked_d;

    logic [NUM_SLOTS-1:0] busy_v, squashed_v, stall_v;
    logic [NUM_SLOTS-1:0] free_hit, sq_hit, issue_hit, resp_hit, fault_hit, wake_hit;
    logic [NUM_SLOTS-1:0] addr_hit, avail, pick_first;
    logic                 pick_any, conflict;

    // Per-slot strobe decode and squash age comparison
    for (genvar gs = 0; gs < NUM_SLOTS; gs++) begin : g_slot
        logic [SEQ_W-1:0] age_diff;
        assign busy_v[gs]     = flags_q[gs].busy;
        assign squashed_v[gs] = flags_q[gs].squashed;
        assign stall_v[gs]    = flags_q[gs].stall;
        assign age_diff       = seq_q[gs] - squash_seq;
        assign free_hit[gs]   = free_valid && (free_slot == SLOT_W'(gs)) && busy_v[gs];
        assign issue_hit[gs]  = issue_valid && (issue_slot == SLOT_W'(gs)) && busy_v[gs];
        assign resp_hit[gs]   = resp_valid && (resp_slot == SLOT_W'(gs)) && busy_v[gs];
        assign fault_hit[gs]  = xlat_fault_valid && (xlat_fault_slot == SLOT_W'(gs)) && busy_v[gs];
        assign wake_hit[gs]   = xlat_wake_valid && (xlat_wake_slot == SLOT_W'(gs)) && busy_v[gs];
        assign sq_hit[gs]     = squash_valid && busy_v[gs] && (tid_q[gs] == squash_tid) &&
                                is_younger(age_diff[SEQ_W-1], |age_diff);
    end

    mst_addr_cam #(.N(NUM_SLOTS), .AW(ADDR_W)) u_cam (
        .entry (addr_q),
        .key   (req_addr),
        .hit   (addr_hit)
    );

    // Port flavour selects whether in-flight addresses block a new request
    if (DATA_PORT) begin : g_data_port
        assign conflict = |(addr_hit & busy_v & ~free_hit);
    end else begin : g_inst_port
        assign conflict = 1'b0;
    end

    // Free-first: a slot released this cycle is already available
    assign avail = ~busy_v | free_hit;

    mst_pick #(.N(NUM_SLOTS)) u_pick (
        .cand  (avail),
        .first (pick_first),
        .any   (pick_any)
    );

    assign grant_valid  = req_valid && !blocked_q[req_tid] && !conflict && pick_any;
    assign grant_slot   = grant_valid ? pick_first : '0;
    assign resp_discard = |(resp_hit & squashed_v);

    // Slot lifecycle
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            flags_d[s] = flags_q[s];
            if (grant_slot[s]) begin
                flags_d[s]      = SLOT_IDLE;
                flags_d[s].busy = 1'b1;
            end else if (free_hit[s]) begin
                flags_d[s] = SLOT_IDLE;
            end else if (busy_v[s]) begin
                if (sq_hit[s]) begin
                    flags_d[s].squashed = 1'b1;
                    if (squash_frees_now(flags_q[s])) flags_d[s].busy = 1'b0;
                end
                if (issue_hit[s]) flags_d[s].pending = 1'b1;
                if (resp_hit[s]) begin
                    flags_d[s].pending = 1'b0;
                    if (squashed_v[s] || sq_hit[s]) flags_d[s].busy = 1'b0;
                end
                if (fault_hit[s]) flags_d[s].stall = 1'b1;
                if (wake_hit[s]) begin
                    flags_d[s].stall = 1'b0;
                    if (squashed_v[s] || sq_hit[s]) flags_d[s].busy = 1'b0;
                end
                if (!flags_d[s].busy) flags_d[s] = SLOT_IDLE;
            end
        end
    end

    // Per-thread translation lockout: a new fault wins over a release
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            logic set_t, clr_t;
            set_t = 1'b0;
            clr_t = 1'b0;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (tid_q[s] == TID_W'(t)) begin
                    set_t = set_t || fault_hit[s];
                    clr_t = clr_t || (stall_v[s] && (wake_hit[s] || sq_hit[s]));
                end
            end
            blocked_d[t] = set_t || (blocked_q[t] && !clr_t);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SLOTS; s++) flags_q[s] <= SLOT_IDLE;
            blocked_q <= '0;
        end else begin
            for (int s = 0; s < NUM_SLOTS; s++) flags_q[s] <= flags_d[s];
            blocked_q <= blocked_d;
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (rst) begin
                addr_q[s] <= '0;
                seq_q[s]  <= '0;
                tid_q[s]  <= '0;
            end else if (grant_slot[s]) begin
                addr_q[s] <= req_addr;
                seq_q[s]  <= req_seq;
                tid_q[s]  <= req_tid;
            end
        end
    end

    assign slot_busy      = busy_v;
    assign thread_blocked = blocked_q;

endmodule

// File: rtl/mem_slot_tracker_chk.sv
module mem_slot_tracker_chk #(
    parameter int NUM_SLOTS   = 4,
    parameter int NUM_THREADS = 2,
    parameter int SLOT_W      = 2,
    parameter int TID_W       = 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic [TID_W-1:0]       req_tid,
    input logic                   grant_valid,
    input logic [NUM_SLOTS-1:0]   grant_slot,
    input logic                   free_valid,
    input logic                   resp_discard,
    input logic [SLOT_W-1:0]      resp_slot,
    input logic                   xlat_fault_valid,
    input logic [SLOT_W-1:0]      xlat_fault_slot,
    input logic [NUM_SLOTS-1:0]   slot_busy,
    input logic [NUM_THREADS-1:0] thread_blocked
);

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (slot_busy == '0) && (thread_blocked == '0)); // R1

    AST_BLOCKED_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && thread_blocked[req_tid]) |-> !grant_valid); // R2

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> ($countones(grant_slot) == 1)); // R5

    AST_NO_GRANT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !grant_valid |-> (grant_slot == '0)); // R5

    AST_GRANT_OCCUPIES: assert property (@(posedge clk) disable iff (rst)
        grant_valid |=> ((slot_busy & $past(grant_slot)) != '0)); // R5

    AST_FULL_REFUSED: assert property (@(posedge clk) disable iff (rst)
        ((&slot_busy) && !free_valid) |-> !grant_valid); // R6

    AST_DISCARD_RELEASES: assert property (@(posedge clk) disable iff (rst)
        resp_discard |=> !slot_busy[$past(resp_slot)]); // R10

    AST_FAULT_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (xlat_fault_valid && slot_busy[xlat_fault_slot]) |=> (thread_blocked != '0)); // R11

endmodule

bind mem_slot_tracker mem_slot_tracker_chk #(
    .NUM_SLOTS   (NUM_SLOTS),
    .NUM_THREADS (NUM_THREADS),
    .SLOT_W      (SLOT_W),
    .TID_W       (TID_W)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .req_valid        (req_valid),
    .req_tid          (req_tid),
    .grant_valid      (grant_valid),
    .grant_slot       (grant_slot),
    .free_valid       (free_valid),
    .resp_discard     (resp_discard),
    .resp_slot        (resp_slot),
    .xlat_fault_valid (xlat_fault_valid),
    .xlat_fault_slot  (xlat_fault_slot),
    .slot_busy        (slot_busy),
    .thread_blocked   (thread_blocked)
);

// File: tb/mem_slot_tracker_test.sv
module mem_slot_tracker_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [0:0]  req_tid;
    logic [15:0] req_seq;
    logic [31:0] req_addr;
    logic        grant_valid, grant_valid_i;
    logic [3:0]  grant_slot, grant_slot_i;
    logic        free_valid;
    logic [1:0]  free_slot;
    logic        squash_valid;
    logic [0:0]  squash_tid;
    logic [15:0] squash_seq;
    logic        issue_valid;
    logic [1:0]  issue_slot;
    logic        resp_valid;
    logic [1:0]  resp_slot;
    logic        resp_discard, resp_discard_i;
    logic        xlat_fault_valid;
    logic [1:0]  xlat_fault_slot;
    logic        xlat_wake_valid;
    logic [1:0]  xlat_wake_slot;
    logic [3:0]  slot_busy, slot_busy_i;
    logic [1:0]  thread_blocked, thread_blocked_i;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mem_slot_tracker uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_tid(req_tid), .req_seq(req_seq),
        .req_addr(req_addr), .grant_valid(grant_valid), .grant_slot(grant_slot),
        .free_valid(free_valid), .free_slot(free_slot), .squash_valid(squash_valid),
        .squash_tid(squash_tid), .squash_seq(squash_seq), .issue_valid(issue_valid),
        .issue_slot(issue_slot), .resp_valid(resp_valid), .resp_slot(resp_slot),
        .resp_discard(resp_discard), .xlat_fault_valid(xlat_fault_valid),
        .xlat_fault_slot(xlat_fault_slot), .xlat_wake_valid(xlat_wake_valid),
        .xlat_wake_slot(xlat_wake_slot), .slot_busy(slot_busy), .thread_blocked(thread_blocked)
    );

    mem_slot_tracker #(.DATA_PORT(1'b0)) uut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_tid(req_tid), .req_seq(req_seq),
        .req_addr(req_addr), .grant_valid(grant_valid_i), .grant_slot(grant_slot_i),
        .free_valid(free_valid), .free_slot(free_slot), .squash_valid(squash_valid),
        .squash_tid(squash_tid), .squash_seq(squash_seq), .issue_valid(issue_valid),
        .issue_slot(issue_slot), .resp_valid(resp_valid), .resp_slot(resp_slot),
        .resp_discard(resp_discard_i), .xlat_fault_valid(xlat_fault_valid),
        .xlat_fault_slot(xlat_fault_slot), .xlat_wake_valid(xlat_wake_valid),
        .xlat_wake_slot(xlat_wake_slot), .slot_busy(slot_busy_i), .thread_blocked(thread_blocked_i)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_tid = 0; req_seq = 0; req_addr = 0;
        free_valid = 0; free_slot = 0; squash_valid = 0; squash_tid = 0; squash_seq = 0;
        issue_valid = 0; issue_slot = 0; resp_valid = 0; resp_slot = 0;
        xlat_fault_valid = 0; xlat_fault_slot = 0; xlat_wake_valid = 0; xlat_wake_slot = 0;
    endtask

    // Called at a falling edge; leaves the bench at the next falling edge with inputs idle.
    task automatic next_cycle();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_req(logic t, logic [15:0] s, logic [31:0] a, logic [3:0] exp, string tag);
        req_valid = 1; req_tid = t; req_seq = s; req_addr = a;
        #2 check(tag, {28'd0, grant_slot}, {28'd0, exp});
        next_cycle();
    endtask

    task automatic do_free(logic [1:0] s);
        free_valid = 1; free_slot = s;
        next_cycle();
    endtask

    // Expected grant from the occupancy model: free-first, address conflict, lowest slot.
    function automatic logic [3:0] model_grant(logic [3:0] busy, logic [31:0] addrs [4],
                                               logic fv, logic [1:0] fs, logic [31:0] a);
        logic [3:0] freeing, open;
        logic dup;
        freeing = fv ? (4'b0001 << fs) & busy : 4'b0000;
        open = ~busy | freeing;
        dup = 1'b0;
        for (int i = 0; i < 4; i++)
            if (busy[i] && !freeing[i] && addrs[i] == a) dup = 1'b1;
        if (dup || open == 4'b0000) return 4'b0000;
        return open & (~open + 4'b0001);
    endfunction

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [3:0]  mbusy;
        logic [31:0] maddr [4];
        logic [15:0] seqc;
        void'($urandom(32'd20240611));
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #2;
        check("R1 busy after reset", {28'd0, slot_busy}, 32'h0);
        check("R1 blocked after reset", {30'd0, thread_blocked}, 32'h0);
        check("R1 no grant after reset", {31'd0, grant_valid}, 32'h0);
        @(negedge clk);

        // Fill the pool
        do_req(1'b0, 16'd10, 32'hA0, 4'b0001, "R5 first grant slot0");
        req_valid = 1; req_tid = 0; req_seq = 16'd11; req_addr = 32'hA0;
        #2 check("R3 duplicate address refused", {28'd0, grant_slot}, 32'h0);
        check("R4 instruction port grants duplicate", {28'd0, grant_slot_i}, 32'h2);
        next_cycle();
        do_req(1'b1, 16'd12, 32'hA1, 4'b0010, "R5 lowest free slot1");
        do_req(1'b0, 16'd13, 32'hA2, 4'b0100, "R5 lowest free slot2");
        do_req(1'b1, 16'd14, 32'hA3, 4'b1000, "R5 lowest free slot3");
        check("R5 all slots busy", {28'd0, slot_busy}, 32'hF);
        do_req(1'b0, 16'd15, 32'hA4, 4'b0000, "R6 full pool refuses");

        // Free-first with the freed slot's own address
        free_valid = 1; free_slot = 2'd1;
        do_req(1'b0, 16'd16, 32'hA1, 4'b0010, "R7 free-first reuse with same address");
        check("R7 pool full again", {28'd0, slot_busy}, 32'hF);

        // Squash thread 0 above seq 12: slot1 (16, pending) and slot2 (13, idle)
        issue_valid = 1; issue_slot = 2'd1;
        next_cycle();
        squash_valid = 1; squash_tid = 0; squash_seq = 16'd12;
        next_cycle();
        check("R8 R9 idle squashed slot released, others kept", {28'd0, slot_busy}, 32'hB);

        resp_valid = 1; resp_slot = 2'd0;
        #2 check("R10 live response kept", {31'd0, resp_discard}, 32'h0);
        next_cycle();
        check("R10 live slot stays busy", {28'd0, slot_busy}, 32'hB);
        resp_valid = 1; resp_slot = 2'd1;
        #2 check("R10 squashed response discarded", {31'd0, resp_discard}, 32'h1);
        next_cycle();
        check("R10 squashed pending slot released", {28'd0, slot_busy}, 32'h9);

        // Wraparound age test
        do_free(2'd0);
        do_free(2'd3);
        do_req(1'b1, 16'hFFFE, 32'hB0, 4'b0001, "R5 grant seq FFFE");
        do_req(1'b1, 16'h0002, 32'hB1, 4'b0010, "R5 grant seq 0002");
        squash_valid = 1; squash_tid = 1; squash_seq = 16'hFFFF;
        next_cycle();
        check("R8 wrapped seq 0002 younger than FFFF", {28'd0, slot_busy}, 32'h1);

        // Translation fault lockout
        xlat_fault_valid = 1; xlat_fault_slot = 2'd0;
        next_cycle();
        check("R11 fault blocks thread1", {30'd0, thread_blocked}, 32'h2);
        do_req(1'b1, 16'd3, 32'hC0, 4'b0000, "R2 blocked thread refused");
        do_req(1'b0, 16'd5, 32'hC1, 4'b0010, "R2 other thread still served");
        xlat_wake_valid = 1; xlat_wake_slot = 2'd0;
        next_cycle();
        check("R11 wake clears lockout", {30'd0, thread_blocked}, 32'h0);
        check("R11 woken live slot kept", {28'd0, slot_busy}, 32'h3);

        // Squash of a translation-stalled slot
        xlat_fault_valid = 1; xlat_fault_slot = 2'd0;
        next_cycle();
        squash_valid = 1; squash_tid = 1; squash_seq = 16'hFFFD;
        next_cycle();
        check("R12 squash lifts lockout", {30'd0, thread_blocked}, 32'h0);
        check("R12 stalled slot kept until wake", {28'd0, slot_busy}, 32'h3);
        xlat_wake_valid = 1; xlat_wake_slot = 2'd0;
        next_cycle();
        check("R12 wake releases squashed slot", {28'd0, slot_busy}, 32'h2);
        do_free(2'd1);
        check("R9 pool empty before random phase", {28'd0, slot_busy}, 32'h0);

        // Random requests and frees against an occupancy model
        mbusy = 4'b0000;
        for (int i = 0; i < 4; i++) maddr[i] = 32'h0;
        seqc = 16'd100;
        for (int n = 0; n < 400; n++) begin
            logic [3:0] exp_g;
            logic [1:0] fs;
            req_valid = ($urandom % 4) != 0;
            req_tid   = 1'($urandom % 2);
            req_seq   = seqc;
            req_addr  = 32'h100 + ($urandom % 6);
            fs        = 2'($urandom % 4);
            free_valid = (($urandom % 3) == 0) && mbusy[fs];
            free_slot  = fs;
            exp_g = req_valid ? model_grant(mbusy, maddr, free_valid, fs, req_addr) : 4'b0000;
            #2 check("R3 R5 R6 R7 random grant", {28'd0, grant_slot}, {28'd0, exp_g});
            if (free_valid) mbusy[fs] = 1'b0;
            for (int i = 0; i < 4; i++) if (exp_g[i]) begin
                mbusy[i] = 1'b1;
                maddr[i] = req_addr;
            end
            seqc = seqc + 16'd1;
            next_cycle();
            if ((n % 25) == 0)
                check("R5 random occupancy", {28'd0, slot_busy}, {28'd0, mbusy});
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule